// File: doc/BRIEF.md
# Character LCD Bus Bridge

This block sits on a Wishbone-style slave port and turns each register access from a processor into one complete bus cycle on a parallel character display with an 8-bit data bus. The slave decodes a window of four word registers: command write, status read, character data write and character data read. For each access it sets the display's register-select and read/write lines, drives or releases the bidirectional data bus, and produces an enable pulse of fixed length. It acknowledges the access only after the display cycle has finished. For a read, it returns on the read data port the byte the display placed on the bus.

The enable pulse width comes from a clock-frequency parameter in MHz, so the pulse lasts at least one microsecond. A parameter value above the real clock frequency only makes the pulse longer. Register-select and read/write settle one or more cycles before the enable rises and stay put one or more cycles after it falls. Display set-up, cursor moves and the waits between commands belong to software.

Top module: `lcd_bus_bridge`

## Requirements
- R1: After reset, and on the cycle after reset is asserted during an access, the enable line and the acknowledge are low, the data bus is released and the read data port is 0.
- R2: Register-select follows word-address bit 1: low for words 0 and 1 (command write, status read), high for words 2 and 3 (data write, data read).
- R3: Read/write is low for writes to words 0 and 2 and high for reads of words 1 and 3.
- R4: An access is taken when strobe and cycle are both high while the block is idle. Register-select and read/write hold their final values on the cycle before the enable rises, and the enable rises on the second clock edge after the access is taken.
- R5: The enable stays high for exactly CLK_MHZ clock cycles.
- R6: Register-select and read/write stay unchanged for one cycle after the enable falls, and the acknowledge follows on the next edge, CLK_MHZ+3 edges after the access was taken.
- R7: During a write, the data bus carries the write data for the whole time the enable is high.
- R8: During a read, the block does not drive the data bus. It captures the bus value on the last enable-high cycle and presents it on the read data port from the acknowledge onward.
- R9: The acknowledge is high for exactly one clock per access.
- R10: Strobe without cycle, or cycle without strobe, starts nothing: no enable pulse and no acknowledge.
- R11: A write to word 1 or 3, or a read of word 0 or 2, runs no display cycle. It is acknowledged on the first edge after it is taken, and the read data port keeps its value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| reset | input | 1 | Synchronous active-high reset |
| bus_wdata | input | DATA_W | Write data from the processor |
| bus_addr | input | ADDR_W | Word address of the register |
| bus_stb | input | 1 | Strobe |
| bus_cyc | input | 1 | Cycle valid |
| bus_we | input | 1 | Write enable (1 = write) |
| bus_rdata | output | DATA_W | Byte captured by the last display read |
| bus_ack | output | 1 | One-cycle acknowledge |
| lcd_enable | output | 1 | Display enable pulse |
| lcd_regsel | output | 1 | Display register select (1 = data) |
| lcd_rdwr | output | 1 | Display read/write (1 = read) |
| lcd_db | inout | DATA_W | Display data bus |

## Verification
A table of accesses covers all four legal registers with different data bytes, including all-ones and all-zeros. This separates the register-select decode from the read/write decode, and shows whether the bus carries the write byte or is captured from the display. A single bit wrong in select, direction or data shows up as a mismatch. Each access is timed edge by edge, so that setup, pulse length, hold and acknowledge position are told apart. Directed cases send accesses in the wrong direction, strobe and cycle alone, and a reset in the middle of a pulse, to show that each is ignored, shortened or aborted.

// File: rtl/lcd_bus_pkg.sv
package lcd_bus_pkg;
  typedef enum logic [2:0] {
    PH_IDLE,
    PH_SETUP,
    PH_PULSE,
    PH_HOLD,
    PH_ACK
  } lcd_phase_e;

  typedef struct packed {
    logic regsel;
    logic rdwr;
  } lcd_op_t;
endpackage

// File: rtl/lcd_access_decode.sv
module lcd_access_decode #(
  parameter int ADDR_W = 2
) (
  input  logic                  stb,
  input  logic                  cyc,
  input  logic                  we,
  input  logic [ADDR_W-1:0]     addr,
  output logic                  request,
  output logic                  legal,
  output lcd_bus_pkg::lcd_op_t  op
);
  localparam int RS_BIT  = 1;
  localparam int DIR_BIT = 0;

  always_comb begin
    request   = stb & cyc;
    // odd words are read registers, even words are write registers
    legal     = addr[DIR_BIT] ^ we;
    op.regsel = addr[RS_BIT];
    op.rdwr   = ~we;
  end

  if (ADDR_W > 2) begin : g_upper
    logic upper_ignored;
    assign upper_ignored = |addr[ADDR_W-1:2];
  end
endmodule

// File: rtl/lcd_phase_timer.sv
module lcd_phase_timer #(
  parameter int CNT_W = 4
) (
  input  logic             clk,
  input  logic             reset,
  input  logic             load,
  input  logic [CNT_W-1:0] load_val,
  output logic             expired
);
  logic [CNT_W-1:0] remain;

  always_ff @(posedge clk) begin
    if (reset)              remain <= '0;
    else if (load)          remain <= load_val;
    else if (remain != '0)  remain <= remain - 1'b1;
  end

  assign expired = (remain == '0);

  AST_TIMER_COUNTS_DOWN: assert property (@(posedge clk) disable iff (reset)
    (!load && remain != '0) |=> (remain == $past(remain) - 1'b1)); // R5
endmodule

// File: rtl/lcd_data_port.sv
module lcd_data_port #(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              reset,
  input  logic              start,
  input  logic              start_write,
  input  logic [DATA_W-1:0] wdata,
  input  logic              capture,
  input  logic              release_bus,
  input  logic [DATA_W-1:0] db_in,
  output logic [DATA_W-1:0] db_out,
  output logic              db_oe,
  output logic [DATA_W-1:0] rdata
);
  always_ff @(posedge clk) begin
    if (reset) begin
      db_out <= '0;
      db_oe  <= 1'b0;
      rdata  <= '0;
    end else begin
      if (start) begin
        db_out <= wdata;
        db_oe  <= start_write;
      end else if (release_bus) begin
        db_oe  <= 1'b0;
      end
      if (capture) rdata <= db_in;
    end
  end

  AST_NO_DRIVE_AND_CAPTURE: assert property (@(posedge clk) disable iff (reset)
    capture |-> !db_oe); // R8
endmodule

// File: rtl/lcd_bus_bridge.sv
module lcd_bus_bridge #(
  parameter int DATA_W    = 8,
  parameter int ADDR_W    = 2,
  parameter int CLK_MHZ   = 100,
  parameter int SETUP_CYC = 1,
  parameter int HOLD_CYC  = 1
) (
  input  logic              clk,
  input  logic              reset,
  input  logic [DATA_W-1:0] bus_wdata,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic              bus_stb,
  input  logic              bus_cyc,
  input  logic              bus_we,
  output logic [DATA_W-1:0] bus_rdata,
  output logic              bus_ack,
  output logic              lcd_enable,
  output logic              lcd_regsel,
  output logic              lcd_rdwr,
  inout  wire  [DATA_W-1:0] lcd_db
);
  import lcd_bus_pkg::*;

  localparam int PULSE_CYC = CLK_MHZ;
  localparam int MAX_LEN   = (PULSE_CYC > SETUP_CYC) ?
                             ((PULSE_CYC > HOLD_CYC) ? PULSE_CYC : HOLD_CYC) :
                             ((SETUP_CYC > HOLD_CYC) ? SETUP_CYC : HOLD_CYC);
  localparam int CNT_W     = $clog2(MAX_LEN + 1);
  localparam logic [CNT_W-1:0] SETUP_LD = CNT_W'(SETUP_CYC - 1);
  localparam logic [CNT_W-1:0] PULSE_LD = CNT_W'(PULSE_CYC - 1);
  localparam logic [CNT_W-1:0] HOLD_LD  = CNT_W'(HOLD_CYC - 1);

  lcd_phase_e        phase;
  lcd_op_t           op;
  logic              request, legal, accept, odd_access;
  logic              expired, t_load;
  logic [CNT_W-1:0]  t_val;
  logic [DATA_W-1:0] db_out, db_in;
  logic              db_oe;

  lcd_access_decode #(.ADDR_W(ADDR_W)) i_decode (
    .stb(bus_stb), .cyc(bus_cyc), .we(bus_we), .addr(bus_addr),
    .request(request), .legal(legal), .op(op)
  );

  assign accept     = (phase == PH_IDLE) && request && legal;
  assign odd_access = (phase == PH_IDLE) && request && !legal;

  always_comb begin
    t_load = 1'b0;
    t_val  = SETUP_LD;
    if (accept) begin
      t_load = 1'b1;
      t_val  = SETUP_LD;
    end else if (phase == PH_SETUP && expired) begin
      t_load = 1'b1;
      t_val  = PULSE_LD;
    end else if (phase == PH_PULSE && expired) begin
      t_load = 1'b1;
      t_val  = HOLD_LD;
    end
  end

  lcd_phase_timer #(.CNT_W(CNT_W)) i_timer (
    .clk(clk), .reset(reset), .load(t_load), .load_val(t_val), .expired(expired)
  );

  lcd_data_port #(.DATA_W(DATA_W)) i_port (
    .clk(clk), .reset(reset),
    .start(accept), .start_write(bus_we), .wdata(bus_wdata),
    .capture((phase == PH_PULSE) && expired && lcd_rdwr),
    .release_bus((phase == PH_HOLD) && expired),
    .db_in(db_in), .db_out(db_out), .db_oe(db_oe), .rdata(bus_rdata)
  );

  assign lcd_db = db_oe ? db_out : {DATA_W{1'bz}};
  assign db_in  = lcd_db;

  always_ff @(posedge clk) begin
    if (reset) begin
      phase      <= PH_IDLE;
      lcd_enable <= 1'b0;
      lcd_regsel <= 1'b0;
      lcd_rdwr   <= 1'b0;
      bus_ack    <= 1'b0;
    end else begin
      case (phase)
        PH_IDLE: begin
          if (accept) begin
            lcd_regsel <= op.regsel;
            lcd_rdwr   <= op.rdwr;
            phase      <= PH_SETUP;
          end else if (odd_access) begin
            bus_ack    <= 1'b1;
            phase      <= PH_ACK;
          end
        end
        PH_SETUP: if (expired) begin
          lcd_enable <= 1'b1;
          phase      <= PH_PULSE;
        end
        PH_PULSE: if (expired) begin
          lcd_enable <= 1'b0;
          phase      <= PH_HOLD;
        end
        PH_HOLD: if (expired) begin
          bus_ack    <= 1'b1;
          phase      <= PH_ACK;
        end
        PH_ACK: begin
          bus_ack    <= 1'b0;
          phase      <= PH_IDLE;
        end
        default: phase <= PH_IDLE;
      endcase
    end
  end

  AST_ACK_SINGLE: assert property (@(posedge clk) disable iff (reset)
    bus_ack |=> !bus_ack); // R9
  AST_SETUP_BEFORE_EN: assert property (@(posedge clk) disable iff (reset)
    $rose(lcd_enable) |-> ($stable(lcd_regsel) && $stable(lcd_rdwr))); // R4
  AST_HOLD_AFTER_EN: assert property (@(posedge clk) disable iff (reset)
    $fell(lcd_enable) |=> ($stable(lcd_regsel) && $stable(lcd_rdwr))); // R6
  AST_NO_ACK_IN_PULSE: assert property (@(posedge clk) disable iff (reset)
    bus_ack |-> !lcd_enable); // R6
  AST_DRIVE_ONLY_ON_WRITE: assert property (@(posedge clk) disable iff (reset)
    db_oe |-> !lcd_rdwr); // R8
  AST_ODD_ACCESS_SHORT: assert property (@(posedge clk) disable iff (reset)
    odd_access |=> (bus_ack && !lcd_enable)); // R11
  AST_IDLE_NEEDS_BOTH: assert property (@(posedge clk) disable iff (reset)
    ((phase == PH_IDLE) && !(bus_stb && bus_cyc)) |=> !bus_ack && !lcd_enable); // R10
endmodule

// File: tb/test_lcd_bus_bridge.sv
module test_lcd_bus_bridge;
  localparam int DW  = 8;
  localparam int AW  = 2;
  localparam int MHZ = 5;
  localparam int NV  = 8;
  // [18]=we [17:16]=word [15:8]=write byte [7:0]=display byte
  localparam logic [18:0] VECS [0:NV-1] = '{
    {1'b1, 2'd0, 8'h38, 8'h00},
    {1'b0, 2'd1, 8'h00, 8'h80},
    {1'b1, 2'd2, 8'h41, 8'h00},
    {1'b0, 2'd3, 8'h00, 8'h5A},
    {1'b1, 2'd2, 8'hFF, 8'h00},
    {1'b0, 2'd3, 8'h00, 8'h00},
    {1'b1, 2'd0, 8'h01, 8'h00},
    {1'b0, 2'd1, 8'h00, 8'h7F}
  };

  logic          clk = 1'b0;
  logic          reset = 1'b1;
  logic [DW-1:0] bus_wdata = '0;
  logic [AW-1:0] bus_addr = '0;
  logic          bus_stb = 1'b0, bus_cyc = 1'b0, bus_we = 1'b0;
  logic [DW-1:0] bus_rdata;
  logic          bus_ack, lcd_enable, lcd_regsel, lcd_rdwr;
  wire  [DW-1:0] lcd_db;
  logic          panel_drive = 1'b0;
  logic [DW-1:0] panel_val = '0;
  int            n_chk = 0, n_bad = 0;

  assign lcd_db = panel_drive ? panel_val : {DW{1'bz}};

  always #10 clk = ~clk;

  lcd_bus_bridge #(.DATA_W(DW), .ADDR_W(AW), .CLK_MHZ(MHZ)) i_lcd_bus_bridge (
    .clk(clk), .reset(reset), .bus_wdata(bus_wdata), .bus_addr(bus_addr),
    .bus_stb(bus_stb), .bus_cyc(bus_cyc), .bus_we(bus_we),
    .bus_rdata(bus_rdata), .bus_ack(bus_ack), .lcd_enable(lcd_enable),
    .lcd_regsel(lcd_regsel), .lcd_rdwr(lcd_rdwr), .lcd_db(lcd_db)
  );

  task automatic check(input string req, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic access(input logic we, input logic [1:0] word,
                        input logic [7:0] wd, input logic [7:0] pv, input bit legal_op);
    int first_en = -1, en_cnt = 0, ack_n = -1, ack_cnt = 0, db_bad = 0;
    logic prev_rs = 1'b0, prev_rw = 1'b0;
    logic rs_pre = 1'b0, rw_pre = 1'b0, rs_rise = 1'b0, rw_rise = 1'b0;
    logic rs_hold = 1'b0, rw_hold = 1'b0;
    logic [7:0] rd_at_ack = '0;
    @(negedge clk);
    bus_we = we; bus_addr = word; bus_wdata = wd;
    bus_stb = 1'b1; bus_cyc = 1'b1;
    panel_val = pv; panel_drive = !we;
    for (int n = 1; n <= MHZ + 8; n++) begin
      @(negedge clk);
      if (lcd_enable) begin
        en_cnt++;
        if (first_en < 0) begin
          first_en = n; rs_pre = prev_rs; rw_pre = prev_rw;
          rs_rise = lcd_regsel; rw_rise = lcd_rdwr;
        end
        if (we && lcd_db !== wd) db_bad++;
      end
      if (n == MHZ + 2) begin rs_hold = lcd_regsel; rw_hold = lcd_rdwr; end
      if (bus_ack) begin
        ack_cnt++; ack_n = n; rd_at_ack = bus_rdata;
        bus_stb = 1'b0; bus_cyc = 1'b0; panel_drive = 1'b0;
      end
      prev_rs = lcd_regsel; prev_rw = lcd_rdwr;
    end
    check("R9 ack count", ack_cnt, 1);
    if (!legal_op) begin
      check("R11 no enable", en_cnt, 0);
      check("R11 ack edge", ack_n, 1);
      return;
    end
    check("R2 regsel at enable", int'(rs_rise), int'(word[1]));
    check("R3 rdwr at enable", int'(rw_rise), int'(!we));
    check("R4 enable edge", first_en, 2);
    check("R4 regsel setup", int'(rs_pre), int'(word[1]));
    check("R4 rdwr setup", int'(rw_pre), int'(!we));
    check("R5 enable width", en_cnt, MHZ);
    check("R6 ack edge", ack_n, MHZ + 3);
    check("R6 regsel hold", int'(rs_hold), int'(word[1]));
    check("R6 rdwr hold", int'(rw_hold), int'(!we));
    if (we) check("R7 bus carries write byte", db_bad, 0);
    else    check("R8 captured byte", int'(rd_at_ack), int'(pv));
  endtask

  task automatic idle_watch(input logic s, input logic c, input string req);
    int hits = 0;
    @(negedge clk);
    bus_stb = s; bus_cyc = c; bus_we = 1'b1; bus_addr = 2'd0; bus_wdata = 8'hA5;
    for (int n = 0; n < 3 * MHZ + 10; n++) begin
      @(negedge clk);
      if (lcd_enable || bus_ack) hits++;
    end
    bus_stb = 1'b0; bus_cyc = 1'b0;
    check(req, hits, 0);
  endtask

  initial begin
    #(20 * 200000);
    n_bad++;
    $display("FAIL watchdog: actual expired expected finished");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    check("R1 enable after reset", int'(lcd_enable), 0);
    check("R1 ack after reset", int'(bus_ack), 0);
    check("R1 rdata after reset", int'(bus_rdata), 0);
    reset = 1'b0;
    for (int v = 0; v < NV; v++)
      access(VECS[v][18], VECS[v][17:16], VECS[v][15:8], VECS[v][7:0], 1'b1);
    // rdata now 8'h7F from last table entry
    access(1'b1, 2'd1, 8'h55, 8'h00, 1'b0);
    check("R11 rdata kept after odd write", int'(bus_rdata), 'h7F);
    access(1'b0, 2'd2, 8'h00, 8'h12, 1'b0);
    check("R11 rdata kept after odd read", int'(bus_rdata), 'h7F);
    idle_watch(1'b1, 1'b0, "R10 strobe alone ignored");
    idle_watch(1'b0, 1'b1, "R10 cycle alone ignored");
    // reset during the enable pulse of a data read
    @(negedge clk);
    bus_we = 1'b0; bus_addr = 2'd3; bus_stb = 1'b1; bus_cyc = 1'b1;
    panel_val = 8'hC3; panel_drive = 1'b1;
    repeat (3) @(negedge clk);
    check("R1 enable high before abort", int'(lcd_enable), 1);
    reset = 1'b1;
    bus_stb = 1'b0; bus_cyc = 1'b0; panel_drive = 1'b0;
    @(negedge clk);
    check("R1 enable dropped by reset", int'(lcd_enable), 0);
    check("R1 ack low after abort", int'(bus_ack), 0);
    check("R1 rdata cleared by reset", int'(bus_rdata), 0);
    @(negedge clk);
    reset = 1'b0;
    access(1'b1, 2'd2, 8'h6B, 8'h00, 1'b1);
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule